// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where instruction fetch goes next in a 32-bit RISC core with fixed 4-byte instructions. Each cycle it takes the address of the current instruction, the low 26 bits of that instruction word (the displacement field), the value of the single source register with its index, and a 3-bit control class from the decoder. One clock later it presents the next program counter, a flag saying the flow was redirected, and a request to write the return address into the link register.

It covers conditional branches that test one register against zero, PC-relative jumps with a long displacement, jumps through a register, and the linking forms of both jump kinds. Register index 0 is hard-wired to zero, so the unit ignores the operand value whenever the index is 0. A register-sourced target that is not word aligned raises a flag. The flow is still redirected to that target, and the core decides what to do with the flag.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `npc_o` equals parameter `RESET_PC` (default 0), and `taken_o`, `link_we_o` and `misalign_o` are 0.
- R2: All outputs are registered. The inputs present at one rising edge of `clk` set the outputs seen after that edge.
- R3: For class 0 (sequential), `npc_o` = `pc_i`+4 and `taken_o` = 0. Class code 7 is undefined and behaves exactly like class 0.
- R4: For class 1 (branch if zero), the branch is taken when the operand is zero. Otherwise `npc_o` = `pc_i`+4 and `taken_o` = 0.
- R5: For class 2 (branch if nonzero), the branch is taken when the operand is nonzero. Otherwise `npc_o` = `pc_i`+4 and `taken_o` = 0.
- R6: A taken branch sets `taken_o` = 1 and `npc_o` = `pc_i`+4+sext(`disp_i[15:0]`). The displacement is a signed byte offset and is not shifted.
- R7: When `rs_idx_i` is 0, the operand counts as zero whatever the value on `rs_val_i`. A class-1 branch on index 0 is therefore always taken, and a class-2 branch on index 0 is never taken.
- R8: Classes 3 (jump) and 4 (jump and link) set `taken_o` = 1 and `npc_o` = `pc_i`+4+sext(`disp_i[25:0]`).
- R9: Classes 5 (jump register) and 6 (jump and link register) set `taken_o` = 1 and `npc_o` = the operand value, with index 0 giving 0.
- R10: Classes 4 and 6 set `link_we_o` = 1 and `link_data_o` = `pc_i`+4. `link_idx_o` is always 31. Every other class gives `link_we_o` = 0.
- R11: `misalign_o` is 1 only for classes 5 and 6 when bits [1:0] of the target are nonzero. The relative forms never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | 32 | Address of the current instruction |
| disp_i | input | 26 | Low 26 bits of the instruction word (displacement field) |
| rs_idx_i | input | 5 | Index of the source register |
| rs_val_i | input | 32 | Value read for the source register |
| ctl_class_i | input | 3 | Decoded control class, codes 0 to 7 |
| npc_o | output | 32 | Next program counter |
| taken_o | output | 1 | Flow redirected away from PC+4 |
| link_we_o | output | 1 | Write request for the link register |
| link_idx_o | output | 5 | Link register index, fixed at 31 |
| link_data_o | output | 32 | Return address for the link write |
| misalign_o | output | 1 | Register target not word aligned |

## Verification
The assertions assume that the control class and the operand are stable and known at each rising edge. They also assume that `rs_val_i` for index 0 may carry any value, because the unit must mask it rather than rely on the register file. The stimulus drives every input on the falling edge and holds it through the next rising edge. It draws random class codes across all eight values, including the undefined one, and random operand values that are forced to zero about a quarter of the time so that both branch outcomes occur often. It also draws random displacements and PCs that wrap near the top of the address space, and deliberately puts garbage on `rs_val_i` while selecting index 0.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [2:0] {
        CLS_SEQ      = 3'd0,
        CLS_BRZ      = 3'd1,
        CLS_BRNZ     = 3'd2,
        CLS_JREL     = 3'd3,
        CLS_JREL_LNK = 3'd4,
        CLS_JREG     = 3'd5,
        CLS_JREG_LNK = 3'd6,
        CLS_RSVD     = 3'd7
    } npc_class_e;

endpackage

// File: rtl/npc_operand.sv
// Masks the register operand for the hard-wired zero register and
// produces the zero test used by both conditional branch forms.
module npc_operand #(
    parameter int XLEN  = 32,
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [XLEN-1:0]  val_i,
    output logic [XLEN-1:0]  opnd_o,
    output logic             is_zero_o
);
    always_comb begin
        opnd_o    = (idx_i == '0) ? '0 : val_i;
        is_zero_o = (opnd_o == '0);
    end
endmodule

// File: rtl/npc_target.sv
// Sequential address and the two PC-relative targets.
module npc_target #(
    parameter int XLEN  = 32,
    parameter int OFF_S = 16,
    parameter int OFF_L = 26
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [OFF_L-1:0] disp_i,
    output logic [XLEN-1:0]  seq_o,
    output logic [XLEN-1:0]  br_tgt_o,
    output logic [XLEN-1:0]  jr_tgt_o
);
    localparam int EXT_S = XLEN - OFF_S;
    localparam int EXT_L = XLEN - OFF_L;

    logic [XLEN-1:0] sext_s;
    logic [XLEN-1:0] sext_l;

    always_comb begin
        sext_s   = {{EXT_S{disp_i[OFF_S-1]}}, disp_i[OFF_S-1:0]};
        sext_l   = {{EXT_L{disp_i[OFF_L-1]}}, disp_i};
        seq_o    = pc_i + XLEN'(4);
        br_tgt_o = seq_o + sext_s;
        jr_tgt_o = seq_o + sext_l;
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
    parameter int          XLEN     = 32,
    parameter int          NUM_REGS = 32,
    parameter int          OFF_S    = 16,
    parameter int          OFF_L    = 26,
    parameter int          LINK_REG = 31,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [XLEN-1:0]             pc_i,
    input  logic [OFF_L-1:0]            disp_i,
    input  logic [$clog2(NUM_REGS)-1:0] rs_idx_i,
    input  logic [XLEN-1:0]             rs_val_i,
    input  logic [2:0]                  ctl_class_i,
    output logic [XLEN-1:0]             npc_o,
    output logic                        taken_o,
    output logic                        link_we_o,
    output logic [$clog2(NUM_REGS)-1:0] link_idx_o,
    output logic [XLEN-1:0]             link_data_o,
    output logic                        misalign_o
);
    import npc_pkg::*;

    localparam int IDX_W = $clog2(NUM_REGS);

    typedef struct packed {
        logic [XLEN-1:0] npc;
        logic            taken;
        logic            link_we;
        logic [XLEN-1:0] link_data;
        logic            misalign;
    } npc_state_t;

    npc_state_t state_d, state_q;

    logic [XLEN-1:0] opnd;
    logic            opnd_zero;
    logic [XLEN-1:0] seq_addr, br_tgt, jr_tgt;
    npc_class_e      cls;

    npc_operand #(.XLEN(XLEN), .IDX_W(IDX_W)) u_opnd (
        .idx_i     (rs_idx_i),
        .val_i     (rs_val_i),
        .opnd_o    (opnd),
        .is_zero_o (opnd_zero)
    );

    npc_target #(.XLEN(XLEN), .OFF_S(OFF_S), .OFF_L(OFF_L)) u_tgt (
        .pc_i     (pc_i),
        .disp_i   (disp_i),
        .seq_o    (seq_addr),
        .br_tgt_o (br_tgt),
        .jr_tgt_o (jr_tgt)
    );

    always_comb begin
        cls               = npc_class_e'(ctl_class_i);
        state_d           = '0;
        state_d.npc       = seq_addr;
        state_d.link_data = seq_addr;
        unique case (cls)
            CLS_BRZ: if (opnd_zero) begin
                state_d.npc   = br_tgt;
                state_d.taken = 1'b1;
            end
            CLS_BRNZ: if (!opnd_zero) begin
                state_d.npc   = br_tgt;
                state_d.taken = 1'b1;
            end
            CLS_JREL, CLS_JREL_LNK: begin
                state_d.npc     = jr_tgt;
                state_d.taken   = 1'b1;
                state_d.link_we = (cls == CLS_JREL_LNK);
            end
            CLS_JREG, CLS_JREG_LNK: begin
                state_d.npc      = opnd;
                state_d.taken    = 1'b1;
                state_d.link_we  = (cls == CLS_JREG_LNK);
                state_d.misalign = (opnd[1:0] != 2'b00);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= '0;
            state_q.npc <= XLEN'(RESET_PC);
        end else begin
            state_q     <= state_d;
        end
    end

    assign npc_o       = state_q.npc;
    assign taken_o     = state_q.taken;
    assign link_we_o   = state_q.link_we;
    assign link_idx_o  = IDX_W'(LINK_REG);
    assign link_data_o = state_q.link_data;
    assign misalign_o  = state_q.misalign;

    // R3: sequential and undefined classes fall through to PC+4
    p_seq_fallthrough_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_class_i == 3'd0 || ctl_class_i == 3'd7)
        |=> (!taken_o && npc_o == $past(pc_i) + XLEN'(4)));

    // R7: a zero-test branch on index 0 is always taken
    p_zero_reg_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_class_i == 3'd1 && rs_idx_i == '0) |=> taken_o);

    // R7: a nonzero-test branch on index 0 is never taken
    p_zero_reg_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_class_i == 3'd2 && rs_idx_i == '0) |=> !taken_o);

    // R10: only the linking classes request a link write
    p_link_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (taken_o && link_data_o == $past(pc_i) + XLEN'(4)));

    // R11: the alignment flag only accompanies a redirect
    p_misalign_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> (taken_o && npc_o[1:0] != 2'b00));

    // R8: relative jumps always redirect
    p_jrel_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_class_i == 3'd3 || ctl_class_i == 3'd4) |=> (taken_o && !misalign_o));
endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0;
    logic [25:0] disp_i = '0;
    logic [4:0]  rs_idx_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [2:0]  ctl_class_i = '0;
    logic [31:0] npc_o, link_data_o;
    logic        taken_o, link_we_o, misalign_o;
    logic [4:0]  link_idx_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_unit i_npc_unit (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .disp_i(disp_i),
        .rs_idx_i(rs_idx_i), .rs_val_i(rs_val_i), .ctl_class_i(ctl_class_i),
        .npc_o(npc_o), .taken_o(taken_o), .link_we_o(link_we_o),
        .link_idx_o(link_idx_o), .link_data_o(link_data_o), .misalign_o(misalign_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] c, input logic [4:0] idx);
        if (idx == 0 && (c == 3'd1 || c == 3'd2)) return "R7";
        case (c)
            3'd1:       return "R4";
            3'd2:       return "R5";
            3'd3, 3'd4: return "R8";
            3'd5, 3'd6: return "R9";
            default:    return "R3";
        endcase
    endfunction

    // Drive on the falling edge, let one rising edge pass, compare (R2).
    task automatic step(input logic [31:0] pc, input logic [25:0] d,
                        input logic [4:0] idx, input logic [31:0] val,
                        input logic [2:0] c);
        logic [31:0] op, seq, e_npc;
        logic        e_tk, e_lw, e_mis;
        string       t;
        @(negedge clk);
        pc_i = pc; disp_i = d; rs_idx_i = idx; rs_val_i = val; ctl_class_i = c;
        op    = (idx == 0) ? 32'h0 : val;
        seq   = pc + 32'd4;
        e_npc = seq; e_tk = 1'b0; e_lw = 1'b0; e_mis = 1'b0;
        case (c)
            3'd1: if (op == 0) begin e_tk = 1'b1; e_npc = seq + {{16{d[15]}}, d[15:0]}; end
            3'd2: if (op != 0) begin e_tk = 1'b1; e_npc = seq + {{16{d[15]}}, d[15:0]}; end
            3'd3, 3'd4: begin e_tk = 1'b1; e_npc = seq + {{6{d[25]}}, d}; e_lw = (c == 3'd4); end
            3'd5, 3'd6: begin e_tk = 1'b1; e_npc = op; e_lw = (c == 3'd6); e_mis = (op[1:0] != 0); end
            default: ;
        endcase
        t = tag_of(c, idx);
        @(posedge clk);
        #1;
        check(t,     "npc",      npc_o,                  e_npc);
        check(t,     "taken",    {31'h0, taken_o},       {31'h0, e_tk});
        check("R10", "link_we",  {31'h0, link_we_o},     {31'h0, e_lw});
        if (e_lw) check("R10", "link_data", link_data_o, seq);
        check("R11", "misalign", {31'h0, misalign_o},    {31'h0, e_mis});
        if (e_tk && (c == 3'd1 || c == 3'd2)) check("R6", "branch target", npc_o, e_npc);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        // R1: reset state, even with a jump class applied
        ctl_class_i = 3'd5; rs_val_i = 32'h1234_5677; rs_idx_i = 5'd3;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "npc reset",      npc_o, 32'h0);
        check("R1", "taken reset",    {31'h0, taken_o}, 32'h0);
        check("R1", "link_we reset",  {31'h0, link_we_o}, 32'h0);
        check("R1", "misalign reset", {31'h0, misalign_o}, 32'h0);
        check("R10", "link index",    {27'h0, link_idx_o}, 32'd31);
        @(negedge clk); rst_n = 1'b1; ctl_class_i = 3'd0;
        #1;
        check("R1", "npc after release", npc_o, 32'h0);

        // directed corners
        step(32'h0000_1000, 26'h000_0010, 5'd4, 32'h0,         3'd1); // R4 taken
        step(32'h0000_1000, 26'h000_FFF0, 5'd4, 32'h5,         3'd1); // R4 not taken
        step(32'h0000_2000, 26'h000_8000, 5'd6, 32'h9,         3'd2); // R5 taken, R6 negative disp
        step(32'h0000_2000, 26'h000_0040, 5'd6, 32'h0,         3'd2); // R5 not taken
        step(32'h0000_3000, 26'h000_0020, 5'd0, 32'hDEAD_BEEF, 3'd1); // R7 always taken
        step(32'h0000_3000, 26'h000_0020, 5'd0, 32'hDEAD_BEEF, 3'd2); // R7 never taken
        step(32'h0040_0000, 26'h200_0000, 5'd1, 32'h0,         3'd3); // R8 most negative
        step(32'hFFFF_FFF8, 26'h000_0100, 5'd1, 32'h0,         3'd4); // R8 wrap, R10 link
        step(32'h0000_4000, 26'h0,        5'd5, 32'h8000_0002, 3'd5); // R9, R11 misaligned
        step(32'h0000_4000, 26'h0,        5'd5, 32'h8000_0004, 3'd6); // R9 aligned, R10
        step(32'h0000_4000, 26'h0,        5'd0, 32'h0000_0003, 3'd6); // R7/R9 index 0 -> 0
        step(32'h0000_5000, 26'h3FF_FFFF, 5'd2, 32'h0,         3'd7); // R3 undefined
        step(32'h0000_5004, 26'h123_4567, 5'd2, 32'h1,         3'd0); // R3 sequential

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] v;
            v = $urandom();
            if ($urandom_range(3) == 0) v = 32'h0;
            step({$urandom()} & 32'hFFFF_FFFC, 26'($urandom()),
                 5'($urandom_range(31)), v, 3'($urandom_range(7)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule